// File: doc/BRIEF.md
# Even Ratio Clock Divider

This block produces a slower clock from one input clock. The ratio is chosen by a small select field and can be any even value from 2 to 16. The output is high for exactly half of each output period and low for the other half. Every output edge is launched by a register clocked by the input clock, so the output carries no combinational glitches.

A synchronous, active-high stop input halts the output cleanly. The stop is only acted on at the end of a complete output period, so a period that has begun always finishes with full-length high and low phases. After stop is released, the divider starts again on the first input clock edge at which stop is sampled low. An optional lead-in, chosen when the divider starts, keeps the output low for one whole output period before its first rising edge. The house reset (`rst_n`, synchronous, active low) returns the block to its stopped state at once.

Top module: `cdiv_even`

## Requirements
- R1: With select value N (3 bits, unsigned), every output period lasts 2*(N+1) input cycles: N+1 cycles high, then N+1 cycles low.
- R2: While `rst_n` is sampled low, the output is low from the next edge onward and the divider is stopped. After release, with `div_stop` low, the output goes high at the first edge where `rst_n` is sampled high.
- R3: `div_stop` is acted on only at the edge that ends a low phase, which is the end of a full period. If it is high there, the output stays low and the divider stops. If it is high only at other edges, it has no effect.
- R4: When the divider is stopped, the output goes high at the first edge where `div_stop` is sampled low, unless the lead-in applies.
- R5: If `lead_en` is 1 at the starting edge, the output stays low for 2*(N+1) cycles after that edge and then rises. The periods that follow obey R1.
- R6: A new select value is adopted only when an output period begins. A change made during a period leaves both phases of that period at the old length.
- R7: Changing `lead_en` while the divider is running has no effect on the output.
- R8: While the divider is stopped, the output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset; stops the divider immediately |
| div_stop | input | 1 | Synchronous active-high stop, honoured at period ends |
| ratio_sel | input | SEL_W | Ratio select N; ratio is 2*(N+1) |
| lead_en | input | 1 | Adds a one-period low lead-in when the divider starts |
| clk_div | output | 1 | Divided clock, registered |

## Verification
The bench builds the divider with the default 3-bit select, so all eight ratios are reachable, from the shortest period of 2 to the longest of 16. This covers the one-cycle phases, where a phase end and a period end are adjacent edges. It also covers the eight-cycle phases, where the counter reaches its top value. Stop pulses that fall inside a period and select changes made during a high phase exercise the rule that only period ends matter. A start with the lead-in enabled and `lead_en` toggling during later periods exercise the one-time nature of the lead-in.

// File: rtl/cdiv_pkg.sv
// Shared types for the even ratio clock divider.
// Assumes: one clock domain; all inputs are synchronous to clk_in.
package cdiv_pkg;

    // Phase of the output waveform being generated.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,   // stopped, output low
        PH_LEAD_A = 3'd1,   // first half of the start-up lead-in (low)
        PH_LEAD_B = 3'd2,   // second half of the start-up lead-in (low)
        PH_HIGH   = 3'd3,   // high half of an output period
        PH_LOW    = 3'd4    // low half of an output period
    } cdiv_phase_e;

endpackage

// File: rtl/cdiv_ratio_reg.sv
// Holds the terminal count (select value N) used for the current period.
// Assumes: load is pulsed only when a period begins, so both phases of
// a period always use the same length.
module cdiv_ratio_reg #(
    parameter int SEL_W = 3
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_in,
    output logic [SEL_W-1:0] term
);

    // Capture the select value at each period start.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            term <= '0;
        end else if (load) begin
            term <= sel_in;
        end
    end

endmodule

// File: rtl/cdiv_phase_cnt.sv
// Counts input cycles within one output phase and flags the last one.
// Assumes: term is stable while run is high within a phase.
module cdiv_phase_cnt #(
    parameter int SEL_W = 3
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] term,
    output logic             wrap
);

    logic [SEL_W-1:0] cnt_q;

    // A phase ends in the cycle where the count reaches the terminal value.
    assign wrap = run && (cnt_q == term);

    // Advance the count while running; clear it at phase ends and when idle.
    always_ff @(posedge clk_in) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/cdiv_seq.sv
// Sequences output phases: start, optional lead-in, high/low alternation
// and the clean stop at period ends. Drives the registered output.
// Assumes: wrap comes from cdiv_phase_cnt and marks a phase's last cycle.
module cdiv_seq
    import cdiv_pkg::*;
(
    input  logic clk_in,
    input  logic rst_n,
    input  logic stop,
    input  logic lead_en,
    input  logic wrap,
    output logic run,
    output logic load,
    output logic out_q
);

    cdiv_phase_e ph_q, ph_d;
    logic        period_end;

    assign run        = (ph_q != PH_IDLE);
    // A low phase (real or lead-in second half) ending closes a full period.
    assign period_end = wrap && ((ph_q == PH_LOW) || (ph_q == PH_LEAD_B));

    // Next phase selection.
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:   if (!stop) ph_d = lead_en ? PH_LEAD_A : PH_HIGH;
            PH_LEAD_A: if (wrap)  ph_d = PH_LEAD_B;
            PH_HIGH:   if (wrap)  ph_d = PH_LOW;
            PH_LEAD_B,
            PH_LOW:    if (wrap)  ph_d = stop ? PH_IDLE : PH_HIGH;
            default:              ph_d = PH_IDLE;
        endcase
    end

    // Load a new ratio whenever a period is about to begin.
    assign load = ((ph_q == PH_IDLE) && !stop) || (period_end && !stop);

    // Phase register and registered output level.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            out_q <= 1'b0;
        end else begin
            ph_q  <= ph_d;
            out_q <= (ph_d == PH_HIGH);
        end
    end

endmodule

// File: rtl/cdiv_even.sv
// Even ratio clock divider top: ratio 2*(N+1), 50 percent duty,
// stop honoured only at period ends, optional one-period lead-in.
// Assumes: all inputs synchronous to clk_in.
module cdiv_even #(
    parameter int SEL_W = 3
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             div_stop,
    input  logic [SEL_W-1:0] ratio_sel,
    input  logic             lead_en,
    output logic             clk_div
);

    logic             run;
    logic             load;
    logic             wrap;
    logic [SEL_W-1:0] term;

    cdiv_ratio_reg #(.SEL_W(SEL_W)) u_ratio (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .load   (load),
        .sel_in (ratio_sel),
        .term   (term)
    );

    cdiv_phase_cnt #(.SEL_W(SEL_W)) u_cnt (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .run    (run),
        .term   (term),
        .wrap   (wrap)
    );

    cdiv_seq u_seq (
        .clk_in  (clk_in),
        .rst_n   (rst_n),
        .stop    (div_stop),
        .lead_en (lead_en),
        .wrap    (wrap),
        .run     (run),
        .load    (load),
        .out_q   (clk_div)
    );

endmodule

// File: rtl/cdiv_even_chk.sv
// Port-level checker for cdiv_even, bound to every instance.
// Assumes: same clock and reset as the divider.
module cdiv_even_chk #(
    parameter int SEL_W = 3
) (
    input logic             clk_in,
    input logic             rst_n,
    input logic             div_stop,
    input logic [SEL_W-1:0] ratio_sel,
    input logic             lead_en,
    input logic             clk_div
);

    localparam int MAXH = 1 << SEL_W;
    localparam int RW   = SEL_W + 3;

    logic [RW-1:0] hi_run;
    logic [RW-1:0] lo_run;

    // Count consecutive high samples, and low samples with stop held low.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else begin
            hi_run <= clk_div ? ((hi_run == '1) ? hi_run : hi_run + 1'b1) : '0;
            lo_run <= (!clk_div && !div_stop)
                      ? ((lo_run == '1) ? lo_run : lo_run + 1'b1) : '0;
        end
    end

    // R1
    hi_len_bound_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        clk_div |-> (hi_run < RW'(MAXH)));

    // R2
    reset_exit_low_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(rst_n) |-> !clk_div);

    // R3
    rise_needs_go_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(clk_div) |-> $past(!div_stop));

    // R5
    lo_len_bound_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!clk_div && !div_stop) |-> (lo_run <= RW'(2 * MAXH)));

endmodule

bind cdiv_even cdiv_even_chk #(.SEL_W(SEL_W)) u_chk (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .div_stop  (div_stop),
    .ratio_sel (ratio_sel),
    .lead_en   (lead_en),
    .clk_div   (clk_div)
);

// File: tb/cdiv_even_tb.sv
module cdiv_even_tb;

    localparam int SEL_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             div_stop = 1'b0;
    logic [SEL_W-1:0] ratio_sel = '0;
    logic             lead_en = 1'b0;
    logic             clk_div;

    int checks = 0;
    int errors = 0;
    string phase_req = "R2";

    always #5 clk = ~clk;

    cdiv_even #(.SEL_W(SEL_W)) u_dut (
        .clk_in    (clk),
        .rst_n     (rst_n),
        .div_stop  (div_stop),
        .ratio_sel (ratio_sel),
        .lead_en   (lead_en),
        .clk_div   (clk_div)
    );

    // Behavioural reference: running flag, cycles left in phase, level, lead phases.
    bit m_run = 0;
    bit m_lvl = 0;
    int m_left = 0;
    int m_lead = 0;
    int m_half = 1;
    bit m_live = 0;

    always @(posedge clk) begin
        m_live = 1;
        if (!rst_n) begin
            m_run = 0; m_lvl = 0; m_left = 0; m_lead = 0;
        end else if (!m_run) begin
            if (!div_stop) begin
                m_run  = 1;
                m_half = int'(ratio_sel) + 1;
                m_left = m_half;
                if (lead_en) begin m_lead = 2; m_lvl = 0; end
                else begin m_lead = 0; m_lvl = 1; end
            end
        end else begin
            m_left--;
            if (m_left == 0) begin
                if (m_lvl) begin
                    m_lvl = 0; m_left = m_half;
                end else if (m_lead == 2) begin
                    m_lead = 1; m_left = m_half;
                end else if (div_stop) begin
                    m_run = 0; m_lead = 0;
                end else begin
                    m_lead = 0; m_half = int'(ratio_sel) + 1;
                    m_lvl = 1; m_left = m_half;
                end
            end
        end
    end

    // Compare output with the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (m_live) begin
            checks++;
            if (clk_div !== m_lvl) begin
                errors++;
                $display("FAIL %s model compare at %0t: actual %b expected %b",
                         phase_req, $time, clk_div, m_lvl);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait (at negedges) until a rising output is seen.
    task automatic wait_rise(output bit ok);
        bit p;
        p  = clk_div;
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (clk_div && !p) begin ok = 1; break; end
            p = clk_div;
        end
    endtask

    // Called at the negedge that first sees high; counts high then low samples.
    task automatic measure(output int hi, output int lo);
        hi = 1; lo = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (clk_div) hi++; else break;
        end
        lo = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!clk_div) lo++; else break;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        int hi, lo, lows;

        repeat (3) @(negedge clk);
        check(clk_div == 1'b0, "R2 reset low", clk_div, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(clk_div == 1'b1, "R2 first edge after release", clk_div, 1);

        // R1: every ratio
        phase_req = "R1";
        for (int s = 0; s < 8; s++) begin
            ratio_sel = SEL_W'(s);
            wait_rise(ok); wait_rise(ok);
            measure(hi, lo);
            check(ok && hi == s + 1, "R1 high length", hi, s + 1);
            check(lo == s + 1, "R1 low length", lo, s + 1);
        end

        // R6: change select during a high phase
        phase_req = "R6";
        ratio_sel = 3'd7;
        wait_rise(ok); wait_rise(ok);
        ratio_sel = 3'd0;
        measure(hi, lo);
        check(hi == 8 && lo == 8, "R6 old ratio kept in current period", hi + lo, 16);
        measure(hi, lo);
        check(hi == 1 && lo == 1, "R6 new ratio next period", hi + lo, 2);

        // R3: stop pulse inside a period is ignored
        phase_req = "R3";
        ratio_sel = 3'd3;
        wait_rise(ok); wait_rise(ok);
        div_stop = 1'b1;
        @(negedge clk);
        div_stop = 1'b0;
        wait_rise(ok);
        check(ok, "R3 mid-period stop ignored", ok, 1);
        measure(hi, lo);
        check(hi == 4 && lo == 4, "R3 period intact after ignored stop", hi + lo, 8);

        // R3/R8: held stop finishes the period and then holds low
        wait_rise(ok);
        div_stop = 1'b1;
        hi = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (clk_div) hi++; else break;
        end
        check(hi == 4, "R3 high phase completes under stop", hi, 4);
        phase_req = "R8";
        lows = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!clk_div) lows++;
        end
        check(lows == 30, "R8 stays low while stopped", lows, 30);

        // R4: restart on first edge with stop low
        phase_req = "R4";
        ratio_sel = 3'd1;
        div_stop = 1'b0;
        @(negedge clk);
        check(clk_div == 1'b1, "R4 restart edge", clk_div, 1);
        measure(hi, lo);
        check(hi == 2 && lo == 2, "R4 ratio after restart", hi + lo, 4);

        // R5: lead-in on start
        phase_req = "R5";
        div_stop = 1'b1;
        repeat (12) @(negedge clk);
        ratio_sel = 3'd2;
        lead_en = 1'b1;
        div_stop = 1'b0;
        @(negedge clk);
        lows = 0;
        for (int i = 0; i < 40; i++) begin
            if (clk_div) break;
            lows++;
            @(negedge clk);
        end
        check(lows == 6, "R5 lead-in low length", lows, 6);
        measure(hi, lo);
        check(hi == 3 && lo == 3, "R5 first period after lead-in", hi + lo, 6);

        // R7: toggling lead_en while running has no effect
        phase_req = "R7";
        lead_en = 1'b0;
        repeat (2) @(negedge clk);
        lead_en = 1'b1;
        wait_rise(ok);
        measure(hi, lo);
        check(ok && hi == 3 && lo == 3, "R7 period unchanged by lead_en", hi + lo, 6);

        // R2: reset in the middle of a high phase forces low at once
        phase_req = "R2";
        wait_rise(ok);
        rst_n = 1'b0;
        @(negedge clk);
        check(clk_div == 1'b0, "R2 reset during high", clk_div, 0);
        repeat (2) @(negedge clk);
        lead_en = 1'b0;
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule